// File: doc/BRIEF.md
# Double-Precision Compare and Condition-Code Unit

This block takes two 64-bit IEEE-754 double-precision values and answers one of two questions about them: are they equal, or is the first smaller than the second. The boolean answer is stored in one bit of an eight-bit condition vector. A 3-bit index picks that bit. The same block also reads the vector back to make control decisions: branch when the chosen bit is set, branch when it is clear, move when it is set, or move when it is clear. It only reports the decision. The program counter and the register file belong to the surrounding pipeline.

Operands that are not numbers are handled with two levels of severity. A quiet NaN always raises the invalid-operation indication, but it requests a trap only when the invalid-trap enable input is high. A signalling NaN requests a trap whatever the enable says.

Each operation is presented for one cycle with `op_valid`. Its results appear on the registered outputs in the following cycle, marked by `res_valid`.

Top module: `fpcmp_cc_unit`

## Requirements
- R1: Operation code 3'd1 (equal) stores 1 in `cc_vec[cc_sel]` when the operands are numerically equal and 0 otherwise.
- R2: Operation code 3'd2 (less-than) stores 1 in `cc_vec[cc_sel]` when `src_a` is numerically smaller than `src_b` and 0 otherwise.
- R3: A compare changes only the bit chosen by `cc_sel` (0 to 7). The decision codes, the unused codes 3'd0 and 3'd7, and idle cycles leave `cc_vec` unchanged.
- R4: Positive zero and negative zero compare as equal, and less-than between them gives 0.
- R5: When both operands are negative, less-than treats the larger magnitude as the smaller value. A negative operand is smaller than any positive one.
- R6: When either operand is a NaN (exponent field bits 62:52 all ones, fraction bits 51:0 nonzero), the stored bit is 0 and `invalid_op` is 1 in the result cycle.
- R7: A quiet NaN (fraction bit 51 = 1) sets `trap_req` only when `invalid_trap_en` is 1.
- R8: A signalling NaN (fraction bit 51 = 0) sets `trap_req` even when `invalid_trap_en` is 0.
- R9: Code 3'd3 sets `branch_take` when `cc_vec[cc_sel]` is 0. Code 3'd4 sets it when that bit is 1.
- R10: Code 3'd5 sets `move_do` when `cc_vec[cc_sel]` is 0. Code 3'd6 sets it when that bit is 1.
- R11: After reset `cc_vec` and all result outputs are 0. Each accepted operation raises `res_valid` in the next cycle. Decision outputs are 0 for compares, and invalid and trap outputs are 0 for decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 1 equal, 2 less-than, 3 branch-if-clear, 4 branch-if-set, 5 move-if-clear, 6 move-if-set |
| cc_sel | input | 3 | Condition bit index |
| src_a | input | 64 | First double operand |
| src_b | input | 64 | Second double operand |
| invalid_trap_en | input | 1 | Trap enable for invalid operation |
| res_valid | output | 1 | Results below belong to the previous cycle's operation |
| cc_vec | output | 8 | Condition vector |
| branch_take | output | 1 | Branch decision |
| move_do | output | 1 | Move decision |
| invalid_op | output | 1 | Invalid-operation indication |
| trap_req | output | 1 | Trap request |

## Verification
The compare is tried with several kinds of operand pair:
- Ordered positive pairs and equal pairs. These separate the equal path from the less-than path.
- Negative pairs and mixed-sign pairs. These show whether the sign-magnitude inversion is applied.
- Zeros of opposite sign. These expose a bitwise equality test where a numeric one is needed.
- Infinities. These must behave as ordinary numbers.
- Quiet and signalling NaNs, each with the trap enable low and high. These separate the two trap policies.

Decisions are checked with the chosen bit both set and clear. Every result also checks the whole condition vector, so a write to the wrong index shows up.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_CEQ  = 3'd1,
    OP_CLT  = 3'd2,
    OP_BRF  = 3'd3,
    OP_BRT  = 3'd4,
    OP_MVF  = 3'd5,
    OP_MVT  = 3'd6,
    OP_RSV  = 3'd7
  } cc_op_e;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
  } fp_class_t;

endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output fp_class_t             cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = val[EXP_W+FRAC_W-1:FRAC_W];
  assign frac_f = val[FRAC_W-1:0];

  always_comb begin
    cls.nan  = (&exp_f) && (|frac_f);
    cls.snan = cls.nan && !frac_f[FRAC_W-1];
    cls.zero = !(|exp_f) && !(|frac_f);
  end
endmodule

// File: rtl/fp_relation.sv
module fp_relation
  import fpcmp_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fp_class_t    cls_a,
  input  fp_class_t    cls_b,
  output logic         eq,
  output logic         lt
);
  logic         sgn_a, sgn_b, any_nan, both_zero;
  logic [W-2:0] mag_a, mag_b;

  assign sgn_a     = a[W-1];
  assign sgn_b     = b[W-1];
  assign mag_a     = a[W-2:0];
  assign mag_b     = b[W-2:0];
  assign any_nan   = cls_a.nan | cls_b.nan;
  assign both_zero = cls_a.zero & cls_b.zero;

  always_comb begin
    eq = !any_nan && ((a == b) || both_zero);
    if (any_nan || both_zero) lt = 1'b0;
    else if (sgn_a != sgn_b)  lt = sgn_a;
    else if (!sgn_a)          lt = (mag_a < mag_b);
    else                      lt = (mag_a > mag_b);
  end

  // NaN never yields a true relation; the two relations never hold together
  always_comb begin
    if (any_nan) assert_nan_false_R6: assert (!eq && !lt);
    assert_eq_lt_excl_R4: assert (!(eq && lt));
  end
endmodule

// File: rtl/cc_bank.sv
module cc_bank
  import fpcmp_pkg::*;
#(
  parameter int CC_N  = 8,
  parameter int IDX_W = $clog2(CC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  cc_op_e           op,
  input  logic [IDX_W-1:0] idx,
  input  logic             eq_res,
  input  logic             lt_res,
  input  logic             any_nan,
  input  logic             any_snan,
  input  logic             inv_en,
  output logic [CC_N-1:0]  cc_q,
  output logic             valid_q,
  output logic             branch_q,
  output logic             move_q,
  output logic             invalid_q,
  output logic             trap_q
);
  logic [CC_N-1:0] cc_d;
  logic            is_cmp, cc_we, sel_bit;
  logic            branch_d, move_d, invalid_d, trap_d;

  always_comb begin
    is_cmp    = op_valid && (op == OP_CEQ || op == OP_CLT);
    cc_we     = is_cmp;
    sel_bit   = cc_q[idx];
    cc_d      = cc_q;
    branch_d  = 1'b0;
    move_d    = 1'b0;
    invalid_d = 1'b0;
    trap_d    = 1'b0;
    if (is_cmp) begin
      cc_d[idx] = (op == OP_CEQ) ? eq_res : lt_res;
      invalid_d = any_nan;
      trap_d    = any_snan | (any_nan & inv_en);
    end else if (op_valid) begin
      case (op)
        OP_BRF:  branch_d = !sel_bit;
        OP_BRT:  branch_d = sel_bit;
        OP_MVF:  move_d   = !sel_bit;
        OP_MVT:  move_d   = sel_bit;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cc_q <= '0;
    else if (cc_we) cc_q <= cc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      branch_q  <= 1'b0;
      move_q    <= 1'b0;
      invalid_q <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      valid_q   <= op_valid;
      branch_q  <= branch_d;
      move_q    <= move_d;
      invalid_q <= invalid_d;
      trap_q    <= trap_d;
    end
  end

  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> ($countones(cc_q ^ $past(cc_q)) <= 1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cmp |=> $stable(cc_q));
  assert_snan_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmp && any_snan) |=> (trap_q && invalid_q));
  assert_qnan_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmp && any_nan && !any_snan && !inv_en) |=> (!trap_q && invalid_q));
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({branch_q, move_q, invalid_q}));
  assert_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> valid_q);
endmodule

// File: rtl/fpcmp_cc_unit.sv
module fpcmp_cc_unit
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int CC_N   = 8,
  parameter int IDX_W  = $clog2(CC_N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [2:0]             op_code,
  input  logic [IDX_W-1:0]       cc_sel,
  input  logic [EXP_W+FRAC_W:0]  src_a,
  input  logic [EXP_W+FRAC_W:0]  src_b,
  input  logic                   invalid_trap_en,
  output logic                   res_valid,
  output logic [CC_N-1:0]        cc_vec,
  output logic                   branch_take,
  output logic                   move_do,
  output logic                   invalid_op,
  output logic                   trap_req
);
  localparam int W = EXP_W + FRAC_W + 1;

  fp_class_t      cls [2];
  logic [W-1:0]   opnd [2];
  logic           eq_res, lt_res;

  assign opnd[0] = src_a;
  assign opnd[1] = src_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .val (opnd[g]),
      .cls (cls[g])
    );
  end

  fp_relation #(.W(W)) rel_i (
    .a     (src_a),
    .b     (src_b),
    .cls_a (cls[0]),
    .cls_b (cls[1]),
    .eq    (eq_res),
    .lt    (lt_res)
  );

  cc_bank #(.CC_N(CC_N), .IDX_W(IDX_W)) bank_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op        (cc_op_e'(op_code)),
    .idx       (cc_sel),
    .eq_res    (eq_res),
    .lt_res    (lt_res),
    .any_nan   (cls[0].nan | cls[1].nan),
    .any_snan  (cls[0].snan | cls[1].snan),
    .inv_en    (invalid_trap_en),
    .cc_q      (cc_vec),
    .valid_q   (res_valid),
    .branch_q  (branch_take),
    .move_q    (move_do),
    .invalid_q (invalid_op),
    .trap_q    (trap_req)
  );
endmodule

// File: tb/fpcmp_cc_unit_tb_top.sv
`timescale 1ns/1ps
module fpcmp_cc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [2:0]  cc_sel;
  logic [63:0] src_a, src_b;
  logic        invalid_trap_en;
  logic        res_valid, branch_take, move_do, invalid_op, trap_req;
  logic [7:0]  cc_vec;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] N3   = 64'hC008000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] NQN  = 64'hFFF8000000000123;

  always #4 clk = ~clk;

  fpcmp_cc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cc_sel(cc_sel), .src_a(src_a), .src_b(src_b),
    .invalid_trap_en(invalid_trap_en), .res_valid(res_valid),
    .cc_vec(cc_vec), .branch_take(branch_take), .move_do(move_do),
    .invalid_op(invalid_op), .trap_req(trap_req)
  );

  // expected item: {cc[7:0], branch, move, invalid, trap}
  logic [11:0] exp_q [$];
  string       tag_q [$];
  logic [7:0]  model_cc = '0;

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic bit is_snan(input logic [63:0] x);
    return is_nan(x) && !x[51];
  endfunction

  task automatic send(input logic [2:0] op, input int idx, input logic [63:0] a,
                      input logic [63:0] b, input logic en, input string tag);
    bit nan, br, mv, inv, trp, sel;
    nan = is_nan(a) || is_nan(b);
    br = 0; mv = 0; inv = 0; trp = 0;
    sel = model_cc[idx];
    case (op)
      3'd1: begin
        model_cc[idx] = !nan && ($bitstoreal(a) == $bitstoreal(b));
        inv = nan; trp = is_snan(a) || is_snan(b) || (nan && en);
      end
      3'd2: begin
        model_cc[idx] = !nan && ($bitstoreal(a) < $bitstoreal(b));
        inv = nan; trp = is_snan(a) || is_snan(b) || (nan && en);
      end
      3'd3: br = !sel;
      3'd4: br = sel;
      3'd5: mv = !sel;
      3'd6: mv = sel;
      default: ;
    endcase
    @(negedge clk);
    exp_q.push_back({model_cc, br, mv, inv, trp});
    tag_q.push_back(tag);
    op_valid = 1'b1; op_code = op; cc_sel = idx[2:0];
    src_a = a; src_b = b; invalid_trap_en = en;
  endtask

  task automatic idle();
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd1; cc_sel = 3'd0;
    src_a = P1; src_b = P1; invalid_trap_en = 1'b0;
  endtask

  // monitor: compare registered results one cycle after each operation
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [11:0] e, act;
      string       t;
      n_run++;
      act = {cc_vec, branch_take, move_do, invalid_op, trap_req};
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11: unexpected result act=%h exp=none", act);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: act cc=%b br=%b mv=%b inv=%b trap=%b exp cc=%b br=%b mv=%b inv=%b trap=%b",
                   t, act[11:4], act[3], act[2], act[1], act[0],
                   e[11:4], e[3], e[2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 1'b0; op_code = 3'd0; cc_sel = 3'd0;
    src_a = PZ; src_b = PZ; invalid_trap_en = 1'b0;
    repeat (3) @(negedge clk);
    n_run++;
    if ({cc_vec, res_valid, branch_take, move_do, invalid_op, trap_req} !== 13'd0) begin
      n_fail++;
      $display("FAIL R11: reset act=%b exp=0",
               {cc_vec, res_valid, branch_take, move_do, invalid_op, trap_req});
    end
    rst_n = 1'b1;

    send(3'd1, 3, P1, P1, 0, "R1");     // equal -> bit3 = 1
    send(3'd1, 4, P1, P2, 0, "R1");     // unequal -> bit4 = 0
    send(3'd2, 0, P1, P2, 0, "R2");     // 1 < 2
    send(3'd2, 1, P2, P1, 0, "R2");     // 2 < 1 false
    send(3'd2, 7, P1, P1, 0, "R2");     // equal not less
    send(3'd1, 2, PINF, PINF, 0, "R1"); // infinities are ordinary
    send(3'd1, 5, PZ, NZ, 0, "R4");     // +0 == -0
    send(3'd2, 6, NZ, PZ, 0, "R4");     // -0 < +0 false
    send(3'd2, 6, N3, N2, 0, "R5");     // -3 < -2
    send(3'd2, 1, N2, N3, 0, "R5");     // -2 < -3 false
    send(3'd2, 4, N1, P1, 0, "R5");     // -1 < 1
    send(3'd2, 4, P1, N1, 0, "R5");     // 1 < -1 false
    send(3'd0, 0, P1, P1, 0, "R3");     // unused code: no change
    send(3'd7, 0, P1, P1, 0, "R3");
    send(3'd1, 3, QNAN, P1, 0, "R6_R7"); // quiet, masked
    send(3'd2, 0, P1, NQN, 1, "R6_R7");  // quiet, enabled
    send(3'd1, 2, SNAN, PINF, 0, "R8");  // signalling, masked still traps
    send(3'd2, 5, P2, SNAN, 1, "R8");
    send(3'd1, 7, P2, P2, 0, "R1");
    send(3'd3, 7, PZ, PZ, 0, "R9");     // bit7 = 1
    send(3'd4, 7, PZ, PZ, 0, "R9");
    send(3'd3, 0, PZ, PZ, 0, "R9");     // bit0 = 0
    send(3'd4, 0, PZ, PZ, 0, "R9");
    send(3'd5, 7, PZ, PZ, 0, "R10");
    send(3'd6, 7, PZ, PZ, 0, "R10");
    send(3'd5, 0, PZ, PZ, 0, "R10");
    send(3'd6, 0, PZ, PZ, 0, "R10");
    idle();
    repeat (3) @(negedge clk);
    n_run++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R11: pending act=%0d exp=0", exp_q.size());
    end
    n_run++;
    if (cc_vec !== model_cc) begin
      n_fail++;
      $display("FAIL R3: idle act=%b exp=%b", cc_vec, model_cc);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule